// File: doc/BRIEF.md
# Event Performance Monitor Unit

This block counts processor activity for profiling. It holds three 32-bit up-counters: two event counters, each fed by one line picked from a vector of single-cycle event pulses, and a cycle counter that advances with the clock. The cycle counter can also advance once every 64 clocks through a divider. A single control word holds the global enable, two reset strobes, the divider select, the two 8-bit event selectors, one interrupt enable per counter and one sticky overflow flag per counter.

Software arms a sample period by writing the two's-complement negative of that period into a counter. The counter then wraps from all-ones to zero after exactly that many counted steps, which sets the counter's overflow flag. When a flag and its interrupt enable are both set, the interrupt line rises. The handler reads the control word and writes it back, and each flag written as 1 is cleared. A wrap that lands in the same cycle as that write-back is not lost.

Access is through a plain synchronous write port with a combinational read of the addressed register. Register addresses are: 0 control, 1 cycle counter, 2 event counter 0, 3 event counter 1.

Top module: `perf_monitor`

## Requirements
- R1: After reset, all registers read 0 and `irq` is 0. A write to address 1, 2 or 3 loads `wdata` into the cycle counter, event counter 0 or event counter 1. A read at that address returns the counter's current value.
- R2: The control word at address 0 has this layout: bit 0 is the global enable, bit 3 the divider select, bits 6:4 the interrupt enables and bits 10:8 the overflow flags. Within bits 6:4 and within bits 10:8, the lowest bit belongs to event counter 0, the next to event counter 1 and the highest to the cycle counter. Bits 27:20 select the event for counter 0 and bits 19:12 select the event for counter 1. Bits 31:28, 11, 7, 2 and 1 always read as 0.
- R3: An event counter increments by one at each clock edge where the registered enable is 1, its selector is below NUM_EVENTS, and the selected `events` bit is 1. A selector at or above NUM_EVENTS never counts, and nothing counts while the enable is 0.
- R4: With the enable set and the divider select clear, the cycle counter increments at every clock edge. With the divider select set, it increments once per 64 enabled clocks. Writing bit 2 as 1 zeroes the cycle counter and the divider phase.
- R5: When a counter steps from all-ones to zero, its overflow flag is set. The flag stays set until a control write with a 1 in that flag's position. Writing 0 to the flag leaves it unchanged.
- R6: If a counter wraps in the same clock as a control write that clears its flag, the flag ends up set.
- R7: `irq` is 1 in the cycle after any counter has both its overflow flag and its interrupt enable set, and is 0 otherwise.
- R8: A control write with bit 1 set zeroes both event counters, and one with bit 2 set zeroes the cycle counter. Either zeroing overrides a load or count in the same clock. A load overrides a count.
- R9: After a counter is preloaded with minus N, exactly N counted steps bring it to 0 and set its overflow flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 2 | Register address (0 control, 1 cycle, 2 event 0, 3 event 1) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data of the addressed register |
| events | input | NUM_EVENTS | Event pulse inputs, one per selectable event |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is a counter wrapping in exactly the clock where software writes back its flag. Both the counter value and the write timing must line up. A directed sequence preloads the cycle counter two steps below wrap, turns counting on, and issues the write-back in the wrap clock. The random phase then keeps preloading counters within sixteen steps of all-ones while control writes with random flag bits arrive, so collisions also occur in event counters and under random selectors. A reference model in the bench, updated every clock, predicts every read and the interrupt line.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
    localparam int DATA_W     = 32;
    localparam int SEL_W      = 8;
    localparam int NUM_CNT    = 3;
    localparam int REG_ADDR_W = 2;

    // control word bit positions
    localparam int EN_BIT    = 0;
    localparam int PCLR_BIT  = 1;
    localparam int CCLR_BIT  = 2;
    localparam int DIV_BIT   = 3;
    localparam int IEN_LSB   = 4;
    localparam int OVF_LSB   = 8;
    localparam int SEL1_LSB  = 12;
    localparam int SEL0_LSB  = 20;

    localparam logic [REG_ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_CYC  = 2'd1;
    localparam logic [REG_ADDR_W-1:0] ADDR_EVT0 = 2'd2;

    // counter index: 0 event 0, 1 event 1, 2 cycle
    localparam int CYC_IDX = 2;

    typedef struct packed {
        logic [SEL_W-1:0]   sel0;
        logic [SEL_W-1:0]   sel1;
        logic [NUM_CNT-1:0] ien;
        logic               div;
        logic               en;
    } pmu_ctrl_t;

    typedef struct packed {
        pmu_ctrl_t          ctrl;
        logic [NUM_CNT-1:0] ovf;
        logic               irq;
    } pmu_state_t;
endpackage

// File: rtl/pmu_event_select.sv
module pmu_event_select #(
    parameter int NUM_EVENTS = 16,
    parameter int SEL_W      = 8
) (
    input  logic [NUM_EVENTS-1:0] events,
    input  logic [SEL_W-1:0]      sel,
    output logic                  hit
);
    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < NUM_EVENTS; i++) begin
            if (sel == SEL_W'(i)) hit = events[i];
        end
    end
endmodule

// File: rtl/pmu_prescaler.sv
module pmu_prescaler #(
    parameter int DIV_LOG2 = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic en,
    output logic tick
);
    logic [DIV_LOG2-1:0] phase_d, phase_q;

    always_comb begin
        phase_d = phase_q;
        tick    = en && (&phase_q);
        if (clear)   phase_d = '0;
        else if (en) phase_d = phase_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] count,
    output logic         wrap
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        wrap  = 1'b0;
        if (clear) begin
            cnt_d = '0;
        end else if (load) begin
            cnt_d = load_val;
        end else if (inc) begin
            cnt_d = cnt_q + 1'b1;
            wrap  = &cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/perf_monitor.sv
module perf_monitor
    import pmu_pkg::*;
#(
    parameter int NUM_EVENTS = 16,
    parameter int CNT_W      = 32,
    parameter int DIV_LOG2   = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    input  logic [NUM_EVENTS-1:0] events,
    output logic                  irq
);
    localparam int NUM_EVT_CNT = NUM_CNT - 1;

    pmu_state_t st_d, st_q;

    logic               wr_ctrl;
    logic               clr_evt;
    logic               clr_cyc;
    logic               div_tick;
    logic [NUM_CNT-1:0] load;
    logic [NUM_CNT-1:0] inc;
    logic [NUM_CNT-1:0] wrap;
    logic [CNT_W-1:0]   cnt [NUM_CNT];

    assign wr_ctrl = wr_en && (addr == ADDR_CTRL);
    assign clr_evt = wr_ctrl && wdata[PCLR_BIT];
    assign clr_cyc = wr_ctrl && wdata[CCLR_BIT];

    // event counters
    for (genvar g = 0; g < NUM_EVT_CNT; g++) begin : g_evt
        logic [SEL_W-1:0] sel;
        logic             hit;

        assign sel     = (g == 0) ? st_q.ctrl.sel0 : st_q.ctrl.sel1;
        assign inc[g]  = st_q.ctrl.en && hit;
        assign load[g] = wr_en && (addr == REG_ADDR_W'(int'(ADDR_EVT0) + g));

        pmu_event_select #(.NUM_EVENTS(NUM_EVENTS), .SEL_W(SEL_W)) u_sel (
            .events (events),
            .sel    (sel),
            .hit    (hit)
        );

        pmu_counter #(.W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (clr_evt),
            .load     (load[g]),
            .load_val (wdata[CNT_W-1:0]),
            .inc      (inc[g]),
            .count    (cnt[g]),
            .wrap     (wrap[g])
        );
    end

    // cycle counter with optional divider
    pmu_prescaler #(.DIV_LOG2(DIV_LOG2)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clr_cyc),
        .en    (st_q.ctrl.en && st_q.ctrl.div),
        .tick  (div_tick)
    );

    assign inc[CYC_IDX]  = st_q.ctrl.en && (!st_q.ctrl.div || div_tick);
    assign load[CYC_IDX] = wr_en && (addr == ADDR_CYC);

    pmu_counter #(.W(CNT_W)) u_cyc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clr_cyc),
        .load     (load[CYC_IDX]),
        .load_val (wdata[CNT_W-1:0]),
        .inc      (inc[CYC_IDX]),
        .count    (cnt[CYC_IDX]),
        .wrap     (wrap[CYC_IDX])
    );

    // control and flag state
    always_comb begin
        logic [NUM_CNT-1:0] clr_mask;
        st_d     = st_q;
        clr_mask = wr_ctrl ? wdata[OVF_LSB +: NUM_CNT] : '0;
        st_d.irq = |(st_q.ovf & st_q.ctrl.ien);
        st_d.ovf = (st_q.ovf & ~clr_mask) | wrap;
        if (wr_ctrl) begin
            st_d.ctrl.en   = wdata[EN_BIT];
            st_d.ctrl.div  = wdata[DIV_BIT];
            st_d.ctrl.ien  = wdata[IEN_LSB +: NUM_CNT];
            st_d.ctrl.sel1 = wdata[SEL1_LSB +: SEL_W];
            st_d.ctrl.sel0 = wdata[SEL0_LSB +: SEL_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // read path
    always_comb begin
        logic [DATA_W-1:0] ctrl_rd;
        ctrl_rd                      = '0;
        ctrl_rd[EN_BIT]              = st_q.ctrl.en;
        ctrl_rd[DIV_BIT]             = st_q.ctrl.div;
        ctrl_rd[IEN_LSB +: NUM_CNT]  = st_q.ctrl.ien;
        ctrl_rd[OVF_LSB +: NUM_CNT]  = st_q.ovf;
        ctrl_rd[SEL1_LSB +: SEL_W]   = st_q.ctrl.sel1;
        ctrl_rd[SEL0_LSB +: SEL_W]   = st_q.ctrl.sel0;
        case (addr)
            2'd0:    rdata = ctrl_rd;
            2'd1:    rdata = DATA_W'(cnt[CYC_IDX]);
            2'd2:    rdata = DATA_W'(cnt[0]);
            default: rdata = DATA_W'(cnt[1]);
        endcase
    end

    assign irq = st_q.irq;

    // observation points for the bound checker
    logic [NUM_CNT-1:0] ovf_flags;
    logic [NUM_CNT-1:0] irq_en;
    logic               cnt_en;
    logic [CNT_W-1:0]   cyc_cnt;
    logic [CNT_W-1:0]   evt0_cnt;

    assign ovf_flags = st_q.ovf;
    assign irq_en    = st_q.ctrl.ien;
    assign cnt_en    = st_q.ctrl.en;
    assign cyc_cnt   = cnt[CYC_IDX];
    assign evt0_cnt  = cnt[0];
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker
    import pmu_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [REG_ADDR_W-1:0] addr,
    input logic [NUM_CNT-1:0]    wr_flag_bits,
    input logic [DATA_W-1:0]     rdata,
    input logic                  irq,
    input logic [NUM_CNT-1:0]    ovf_flags,
    input logic [NUM_CNT-1:0]    irq_en,
    input logic                  cnt_en,
    input logic [CNT_W-1:0]      cyc_cnt,
    input logic [CNT_W-1:0]      evt0_cnt
);
    logic [NUM_CNT-1:0] clr_mask;
    assign clr_mask = (wr_en && addr == ADDR_CTRL) ? wr_flag_bits : '0;

    // R7: interrupt mirrors qualified flags one cycle late
    assert_irq_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(|(ovf_flags & irq_en)));

    // R5: a flag only drops when written as 1
    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(ovf_flags) & ~$past(clr_mask) & ~ovf_flags) == '0));

    // R2: write-as-zero and strobe bits read as zero
    assert_ctrl_zero_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_CTRL) |-> ((rdata & 32'hF000_0886) == 32'h0));

    // R4: cycle counter frozen while disabled and not written
    assert_cycle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cnt_en) && !$past(wr_en)) |-> $stable(cyc_cnt));

    // R3: an event counter moves by at most one step without a write
    assert_event_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> (evt0_cnt == $past(evt0_cnt) ||
                           evt0_cnt == $past(evt0_cnt) + 1'b1));
endmodule

bind perf_monitor pmu_checker #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .addr         (addr),
    .wr_flag_bits (wdata[pmu_pkg::OVF_LSB +: pmu_pkg::NUM_CNT]),
    .rdata        (rdata),
    .irq          (irq),
    .ovf_flags    (ovf_flags),
    .irq_en       (irq_en),
    .cnt_en       (cnt_en),
    .cyc_cnt      (cyc_cnt),
    .evt0_cnt     (evt0_cnt)
);

// File: tb/tb_perf_monitor.sv
`timescale 1ns/1ps
module tb_perf_monitor;
    localparam int NE = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    addr = 2'd0;
    logic [31:0]   wdata = 32'h0;
    logic [31:0]   rdata;
    logic [NE-1:0] events = '0;
    logic          irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    perf_monitor #(.NUM_EVENTS(NE)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .events(events), .irq(irq)
    );

    always #10 clk = ~clk;

    // reference model state
    logic        m_e, m_d, m_irq;
    logic [2:0]  m_ien, m_ovf;
    logic [7:0]  m_sel0, m_sel1;
    logic [5:0]  m_pre;
    logic [31:0] m_cyc, m_e0, m_e1;

    task automatic model_reset();
        m_e = 0; m_d = 0; m_irq = 0; m_ien = 0; m_ovf = 0;
        m_sel0 = 0; m_sel1 = 0; m_pre = 0; m_cyc = 0; m_e0 = 0; m_e1 = 0;
    endtask

    function automatic logic [31:0] mread(input logic [1:0] a);
        case (a)
            2'd0: return {4'b0, m_sel0, m_sel1, 1'b0, m_ovf, 1'b0, m_ien, m_d, 2'b0, m_e};
            2'd1: return m_cyc;
            2'd2: return m_e0;
            default: return m_e1;
        endcase
    endfunction

    function automatic logic evhit(input logic [7:0] s, input logic [NE-1:0] ev);
        return (s < NE) ? ev[s[3:0]] : 1'b0;
    endfunction

    task automatic model_step(input logic w, input logic [1:0] a,
                              input logic [31:0] d, input logic [NE-1:0] ev);
        logic wc, pc, cc, ptick, ic, i0, i1;
        logic [2:0] wr_flags, clr;
        wc = w && a == 2'd0;
        pc = wc && d[1];
        cc = wc && d[2];
        ptick = m_e && m_d && (m_pre == 6'd63);
        ic = m_e && (!m_d || ptick);
        i0 = m_e && evhit(m_sel0, ev);
        i1 = m_e && evhit(m_sel1, ev);
        wr_flags = 3'b0;
        clr = wc ? d[10:8] : 3'b0;
        m_irq = |(m_ovf & m_ien);
        if (cc) m_cyc = 0;
        else if (w && a == 2'd1) m_cyc = d;
        else if (ic) begin wr_flags[2] = (m_cyc == 32'hFFFF_FFFF); m_cyc = m_cyc + 1; end
        if (pc) m_e0 = 0;
        else if (w && a == 2'd2) m_e0 = d;
        else if (i0) begin wr_flags[0] = (m_e0 == 32'hFFFF_FFFF); m_e0 = m_e0 + 1; end
        if (pc) m_e1 = 0;
        else if (w && a == 2'd3) m_e1 = d;
        else if (i1) begin wr_flags[1] = (m_e1 == 32'hFFFF_FFFF); m_e1 = m_e1 + 1; end
        if (cc) m_pre = 0;
        else if (m_e && m_d) m_pre = m_pre + 1;
        m_ovf = (m_ovf & ~clr) | wr_flags;
        if (wc) begin
            m_e = d[0]; m_d = d[3]; m_ien = d[6:4]; m_sel1 = d[19:12]; m_sel0 = d[27:20];
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock: drive, compare current outputs with model, advance
    task automatic tick(input logic w, input logic [1:0] a,
                        input logic [31:0] d, input logic [NE-1:0] ev);
        wr_en = w; addr = a; wdata = d; events = ev;
        #1;
        check((a == 2'd0) ? "R2 read" : "R1 read", rdata, mread(a));
        check("R7 irq", {31'b0, irq}, {31'b0, m_irq});
        @(posedge clk);
        model_step(w, a, d, ev);
        @(negedge clk);
    endtask

    task automatic peek(input logic [1:0] a, output logic [31:0] v);
        wr_en = 1'b0; addr = a;
        #1;
        v = rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5EED_1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            peek(2'(a), v);
            check("R1 reset value", v, 32'h0);
        end
        check("R1 reset irq", {31'b0, irq}, 32'h0);

        // R2: all-ones write, reserved and strobe bits read zero
        tick(1, 2'd0, 32'hFFFF_FFFF, '1);
        peek(2'd0, v);
        check("R2 ctrl layout", v, 32'h0FFF_F079);
        // R3: selector 255 is out of range, never counts
        repeat (5) tick(0, 2'd2, 32'h0, '1);
        peek(2'd2, v); check("R3 out-of-range sel evt0", v, 32'h0);
        peek(2'd3, v); check("R3 out-of-range sel evt1", v, 32'h0);
        peek(2'd1, v); check("R4 divided cycle count early", v, 32'h0);
        tick(1, 2'd0, 32'h0, '0);

        // R9: preload -3, three selected events wrap event counter 0
        tick(1, 2'd2, 32'hFFFF_FFFD, '0);
        tick(1, 2'd0, (32'd2 << 20) | 32'h11, '0);
        repeat (3) tick(0, 2'd0, 32'h0, 16'h0004);
        peek(2'd2, v); check("R9 counter at zero", v, 32'h0);
        peek(2'd0, v); check("R9 flag set", {31'b0, v[8]}, 32'h1);
        check("R7 irq lags flag", {31'b0, irq}, 32'h0);
        tick(0, 2'd0, 32'h0, '0);
        check("R7 irq raised", {31'b0, irq}, 32'h1);
        // R5: writing 0 keeps the flag, writing 1 clears it
        tick(1, 2'd0, (32'd2 << 20) | 32'h11, '0);
        peek(2'd0, v); check("R5 flag kept on zero write", {31'b0, v[8]}, 32'h1);
        tick(1, 2'd0, (32'd2 << 20) | 32'h111, '0);
        peek(2'd0, v); check("R5 flag cleared", {31'b0, v[8]}, 32'h0);
        tick(0, 2'd0, 32'h0, '0);
        check("R7 irq dropped", {31'b0, irq}, 32'h0);

        // R6: wrap in the same clock as the flag write-back
        tick(1, 2'd0, 32'h0, '0);
        tick(1, 2'd1, 32'hFFFF_FFFE, '0);
        tick(1, 2'd0, 32'h1, '0);
        tick(0, 2'd0, 32'h0, '0);
        tick(1, 2'd0, 32'h401, '0);
        peek(2'd0, v); check("R6 flag survives collision", {31'b0, v[10]}, 32'h1);
        peek(2'd1, v); check("R6 cycle wrapped", v, 32'h0);
        tick(1, 2'd0, 32'h400, '0);

        // R4: divider, cleared by bit 2
        tick(1, 2'd0, 32'hD, '0);
        repeat (128) tick(0, 2'd1, 32'h0, '0);
        peek(2'd1, v); check("R4 divide by 64", v, 32'd2);

        // R8: bit 1 zeroes event counters, cycle counter kept
        tick(1, 2'd2, 32'd50, '0);
        tick(1, 2'd3, 32'd100, '0);
        tick(1, 2'd0, 32'h2, '0);
        peek(2'd2, v); check("R8 evt0 cleared", v, 32'h0);
        peek(2'd3, v); check("R8 evt1 cleared", v, 32'h0);
        peek(2'd1, v); check("R8 cycle kept", v, 32'd2);
        tick(1, 2'd0, 32'h4, '0);
        peek(2'd1, v); check("R8 cycle cleared", v, 32'h0);

        // R1 R3 R4 R5 R7 R8: random mix checked against the model
        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            logic [31:0] d;
            r = $urandom % 100;
            d = $urandom;
            if (r < 6) begin
                d[27:20] = 8'($urandom % 20);
                d[19:12] = 8'($urandom % 20);
                d[0] = ($urandom % 4) != 0;
                d[1] = ($urandom % 8) == 0;
                d[2] = ($urandom % 8) == 0;
                d[3] = ($urandom % 4) == 0;
                tick(1, 2'd0, d, NE'($urandom));
            end else if (r < 10) begin
                tick(1, 2'(1 + $urandom % 3), 32'hFFFF_FFF0 | (d & 32'hF), NE'($urandom));
            end else begin
                tick(0, 2'($urandom % 4), d, NE'($urandom));
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule